// File: doc/BRIEF.md
# Dual-Mode Wakeup Interrupt Forwarder

This block stands between a set of GPIO wakeup interrupt lines and a downstream interrupt controller. It also carries a group of direct shared-peripheral interrupt lines straight through. A mode register selects how the GPIO lines are treated. In pass-through mode each enabled GPIO input is copied to its output with no latching. In secondary mode each enabled GPIO input is watched for its configured trigger: high level, low level, rising edge, falling edge or either edge. A hit sets a pending latch, which is shown downstream as a level interrupt unless the pin's mask bit is set.

Software reaches the block through a small synchronous register bus. Each pin has a configuration word that holds its trigger type, enable, mask and a write-one clear strobe. A read-only version word reports the block revision. The mode register can be written, but a read of it returns zero. A build parameter selects an older layout: in that layout the mask sits in bit 3 and the enables live in separate bank words. The default layout, described below, puts the enable in bit 3 and the mask in bit 4.

Top module: `wf_forwarder`

## Requirements
- R1: In pass-through mode (mode bit 0), `gpio_irq_out[i]` equals `gpio_in[i]` AND the pin's enable, one clock after the input is sampled, and nothing is held once the input falls.
- R2: `spi_irq_out` equals `spi_in` one clock later in both modes, with no latching.
- R3: In secondary mode (mode bit 1), an enabled pin latches when its trigger type (config bits 2:0) fires: 0 is level high, 1 is level low, 2 is rising edge, 3 is falling edge, 4 is either edge. Edges are judged against the previous clock's sample. The latched output appears two clocks after the input change and stays high after the input returns.
- R4: Mask (config bit 4, set = blocked) stops forwarding in secondary mode only. A latch taken while masked is kept and shows once the pin is unmasked. In pass-through mode the mask has no effect.
- R5: A pin whose enable (config bit 3) is 0 neither latches nor forwards, in either mode.
- R6: Writing a config word with bit 8 set clears that pin's latch. The clear wins over a trigger hit in the same cycle, so a level-high pin whose input is still high shows 0 for exactly one clock, two clocks after the write cycle.
- R7: The mode register at offset 0x1004, bit 0, reads as 0. A write that changes the mode clears every pending latch.
- R8: Pin config words sit at 0x110 + 4*pin and read back bits 4:0 as written, with bit 8 reading 0. The version word at 0x1000 reads the VERSION parameter (default 0x30200). Read data is valid one clock after `bus_re`.
- R9: After reset both output vectors are 0, the mode is pass-through and every config word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | N_GPIO | GPIO wakeup interrupt inputs, synchronous to clk |
| spi_in | input | N_SPI | Direct interrupt inputs |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| gpio_irq_out | output | N_GPIO | Forwarded GPIO interrupts, registered |
| spi_irq_out | output | N_SPI | Forwarded direct interrupts, registered |

## Verification
Different results come back after different delays. Pass-through GPIO outputs, direct interrupt outputs and read data each show up one clock after the stimulus edge. A latched secondary-mode output shows up two clocks after the input change, and a mask, enable or mode write shows up two clocks after the write. The scoreboard tags each expected item with the clock number when it is due, counted from the negative edge where the driver applied the stimulus. The monitor samples just after each rising edge and compares only the items due in that clock. The clear-priority and latch-timing cases check the exact cycle. Steady-state cases check a few clocks later, once the outputs have settled.

// File: rtl/wf_pkg.sv
package wf_pkg;
  typedef enum logic [2:0] {
    TRIG_HIGH = 3'd0,
    TRIG_LOW  = 3'd1,
    TRIG_RISE = 3'd2,
    TRIG_FALL = 3'd3,
    TRIG_BOTH = 3'd4
  } trig_e;

  localparam int unsigned BANK_BASE = 32'h0010;
  localparam int unsigned CFG_BASE  = 32'h0110;
  localparam int unsigned VER_ADDR  = 32'h1000;
  localparam int unsigned MODE_ADDR = 32'h1004;
  localparam int unsigned CLR_BIT   = 8;

  function automatic logic trig_hit(input logic [2:0] t, input logic cur, input logic prev);
    case (t)
      TRIG_HIGH: return cur;
      TRIG_LOW:  return !cur;
      TRIG_RISE: return cur && !prev;
      TRIG_FALL: return !cur && prev;
      TRIG_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/wf_regs.sv
module wf_regs #(
  parameter int N_GPIO     = 16,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int VERSION    = 32'h30200,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_we,
  input  logic                     bus_re,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [N_GPIO-1:0][2:0]   trig_o,
  output logic [N_GPIO-1:0]        en_o,
  output logic [N_GPIO-1:0]        mask_o,
  output logic [N_GPIO-1:0]        clr_o,
  output logic                     sec_mode_o,
  output logic                     clr_all_o
);
  import wf_pkg::*;

  localparam int IDX_W  = (N_GPIO > 1) ? $clog2(N_GPIO) : 1;
  localparam int N_BANK = (N_GPIO + 31) / 32;
  localparam int BK_W   = (N_BANK > 1) ? $clog2(N_BANK) : 1;
  localparam logic [4:0] KEEP = NEW_LAYOUT ? 5'h1F : 5'h0F;
  localparam logic [ADDR_W-1:0] CFG_LO  = ADDR_W'(CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI  = ADDR_W'(CFG_BASE + 4 * N_GPIO);
  localparam logic [ADDR_W-1:0] BANK_LO = ADDR_W'(BANK_BASE);
  localparam logic [ADDR_W-1:0] BANK_HI = ADDR_W'(BANK_BASE + 4 * N_BANK);

  logic [N_GPIO-1:0][4:0] cfg_q;
  logic                   sec_q;
  logic [DATA_W-1:0]      rdata_q, rd_mux;
  logic [ADDR_W-1:0]      cfg_off, bank_off;
  logic [IDX_W-1:0]       cfg_idx;
  logic [BK_W-1:0]        bank_idx;
  logic                   cfg_hit, bank_hit, ver_hit, mode_hit;
  logic [N_BANK*32-1:0]   bank_q;

  assign cfg_off  = bus_addr - CFG_LO;
  assign bank_off = bus_addr - BANK_LO;
  assign cfg_idx  = cfg_off[IDX_W+1:2];
  assign bank_idx = bank_off[BK_W+1:2];
  assign cfg_hit  = (bus_addr[1:0] == 2'b00) && (bus_addr >= CFG_LO) && (bus_addr < CFG_HI);
  assign bank_hit = !NEW_LAYOUT && (bus_addr[1:0] == 2'b00) &&
                    (bus_addr >= BANK_LO) && (bus_addr < BANK_HI);
  assign ver_hit  = (bus_addr == ADDR_W'(VER_ADDR));
  assign mode_hit = (bus_addr == ADDR_W'(MODE_ADDR));

  // per-pin configuration words
  for (genvar i = 0; i < N_GPIO; i++) begin : g_cfg
    logic sel;
    assign sel = bus_we && cfg_hit && (cfg_idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) cfg_q[i] <= '0;
      else if (sel) cfg_q[i] <= bus_wdata[4:0] & KEEP;
    end
    assign clr_o[i]  = sel && bus_wdata[CLR_BIT];
    assign trig_o[i] = cfg_q[i][2:0];
  end

  // layout variant: where enable and mask live
  if (NEW_LAYOUT) begin : g_new
    for (genvar i = 0; i < N_GPIO; i++) begin : g_bits
      assign en_o[i]   = cfg_q[i][3];
      assign mask_o[i] = cfg_q[i][4];
    end
    assign bank_q = '0;
  end else begin : g_old
    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (rst) bank_q[b*32 +: 32] <= '0;
        else if (bus_we && bank_hit && (bank_idx == BK_W'(b)))
          bank_q[b*32 +: 32] <= bus_wdata[31:0];
      end
    end
    for (genvar i = 0; i < N_GPIO; i++) begin : g_bits
      assign en_o[i]   = bank_q[i];
      assign mask_o[i] = cfg_q[i][3];
    end
  end

  // mode register, write only
  assign clr_all_o = bus_we && mode_hit && (bus_wdata[0] != sec_q);
  always_ff @(posedge clk) begin
    if (rst) sec_q <= 1'b0;
    else if (bus_we && mode_hit) sec_q <= bus_wdata[0];
  end
  assign sec_mode_o = sec_q;

  // read path
  always_comb begin
    rd_mux = '0;
    if (ver_hit)       rd_mux = DATA_W'(VERSION);
    else if (cfg_hit)  rd_mux = DATA_W'(cfg_q[cfg_idx]);
    else if (bank_hit) rd_mux = DATA_W'(bank_q[32*bank_idx +: 32]);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_re) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  a_r7_mode_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_re && mode_hit) |=> (bus_rdata == '0));
  a_r8_version_read: assert property (@(posedge clk) disable iff (rst)
    (bus_re && ver_hit) |=> (bus_rdata == DATA_W'(VERSION)));
endmodule

// File: rtl/wf_pin_latch.sv
module wf_pin_latch #(
  parameter int N_GPIO = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GPIO-1:0]      gpio_i,
  input  logic [N_GPIO-1:0][2:0] trig_i,
  input  logic [N_GPIO-1:0]      en_i,
  input  logic [N_GPIO-1:0]      clr_i,
  input  logic                   sec_mode_i,
  input  logic                   clr_all_i,
  output logic [N_GPIO-1:0]      pend_o
);
  import wf_pkg::*;

  logic [N_GPIO-1:0] prev_q, pend_q, hit;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= gpio_i;
  end

  for (genvar i = 0; i < N_GPIO; i++) begin : g_pin
    assign hit[i] = trig_hit(trig_i[i], gpio_i[i], prev_q[i]) && en_i[i];
    always_ff @(posedge clk) begin
      if (rst || clr_all_i || !sec_mode_i) pend_q[i] <= 1'b0;
      else if (clr_i[i])                   pend_q[i] <= 1'b0;
      else if (hit[i])                     pend_q[i] <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_i != '0) |=> ((pend_o & $past(clr_i)) == '0));
  a_r5_disabled_no_latch: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(en_i)) == '0));
  a_r7_switch_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_all_i || !sec_mode_i) |=> (pend_o == '0));
endmodule

// File: rtl/wf_route.sv
module wf_route #(
  parameter int N_GPIO = 16,
  parameter int N_SPI  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_mode_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic [N_GPIO-1:0] pend_i,
  input  logic [N_GPIO-1:0] en_i,
  input  logic [N_GPIO-1:0] mask_i,
  input  logic [N_SPI-1:0]  spi_i,
  output logic [N_GPIO-1:0] gpio_o,
  output logic [N_SPI-1:0]  spi_o
);
  logic [N_GPIO-1:0] gpio_q;
  logic [N_SPI-1:0]  spi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gpio_q <= '0;
      spi_q  <= '0;
    end else begin
      gpio_q <= sec_mode_i ? (pend_i & en_i & ~mask_i) : (gpio_i & en_i);
      spi_q  <= spi_i;
    end
  end

  assign gpio_o = gpio_q;
  assign spi_o  = spi_q;

  a_r2_spi_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (spi_o == $past(spi_i)));
  a_r1_pass_follow: assert property (@(posedge clk) disable iff (rst)
    !sec_mode_i |=> (gpio_o == $past(gpio_i & en_i)));
  a_r4_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    sec_mode_i |=> ((gpio_o & $past(mask_i)) == '0));
endmodule

// File: rtl/wf_forwarder.sv
module wf_forwarder #(
  parameter int N_GPIO     = 16,
  parameter int N_SPI      = 4,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int VERSION    = 32'h30200,
  parameter bit NEW_LAYOUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_GPIO-1:0] gpio_in,
  input  logic [N_SPI-1:0]  spi_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_GPIO-1:0] gpio_irq_out,
  output logic [N_SPI-1:0]  spi_irq_out
);
  logic [N_GPIO-1:0][2:0] trig;
  logic [N_GPIO-1:0]      en, mask, clr, pend;
  logic                   sec_mode, clr_all;

  wf_regs #(
    .N_GPIO(N_GPIO), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .VERSION(VERSION), .NEW_LAYOUT(NEW_LAYOUT)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_o(trig), .en_o(en), .mask_o(mask), .clr_o(clr),
    .sec_mode_o(sec_mode), .clr_all_o(clr_all)
  );

  wf_pin_latch #(.N_GPIO(N_GPIO)) u_latch (
    .clk(clk), .rst(rst), .gpio_i(gpio_in), .trig_i(trig), .en_i(en),
    .clr_i(clr), .sec_mode_i(sec_mode), .clr_all_i(clr_all), .pend_o(pend)
  );

  wf_route #(.N_GPIO(N_GPIO), .N_SPI(N_SPI)) u_route (
    .clk(clk), .rst(rst), .sec_mode_i(sec_mode), .gpio_i(gpio_in),
    .pend_i(pend), .en_i(en), .mask_i(mask), .spi_i(spi_in),
    .gpio_o(gpio_irq_out), .spi_o(spi_irq_out)
  );
endmodule

// File: tb/tb_wf_forwarder.sv
module tb_wf_forwarder;
  localparam int NG = 16;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NG-1:0] gpio_in = '0;
  logic [NS-1:0] spi_in = '0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NG-1:0] gpio_irq_out;
  logic [NS-1:0] spi_irq_out;

  wf_forwarder dut (
    .clk(clk), .rst(rst), .gpio_in(gpio_in), .spi_in(spi_in),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_irq_out(gpio_irq_out), .spi_irq_out(spi_irq_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;   // 0 gpio out, 1 spi out, 2 read data
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // monitor: sample just after each rising edge
  always @(posedge clk) begin
    logic [31:0] act;
    int i;
    #1;
    cyc++;
    i = 0;
    while (i < q.size()) begin
      if (q[i].due == cyc) begin
        case (q[i].kind)
          0: act = 32'(gpio_irq_out);
          1: act = 32'(spi_irq_out);
          default: act = bus_rdata;
        endcase
        n_run++;
        if (act !== q[i].exp) begin
          n_fail++;
          $display("FAIL %s: cycle %0d kind %0d actual 0x%0h expected 0x%0h",
                   q[i].req, cyc, q[i].kind, act, q[i].exp);
        end
        q.delete(i);
      end else i++;
    end
  end

  task automatic expect_at(input int dly, input int kind, input logic [31:0] v, input string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  // all drivers are entered at a negative edge and leave at the next one
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] e, input string req);
    bus_re = 1'b1; bus_addr = a;
    expect_at(1, 2, e, req);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic drive(input logic [NG-1:0] g);
    gpio_in = g;
    @(negedge clk);
  endtask

  function automatic logic [15:0] cfg_a(input int pin);
    return 16'(32'h110 + 4 * pin);
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    expect_at(1, 0, 32'h0, "R9");
    expect_at(1, 1, 32'h0, "R9");
    idle(1);
    rd(cfg_a(0), 32'h0, "R9");
    idle(1);

    // pass-through mode: bit3 enable, bit4 mask
    wr(cfg_a(0), 32'h08);
    wr(cfg_a(1), 32'h18);
    wr(cfg_a(2), 32'h08);
    wr(cfg_a(3), 32'h08);
    expect_at(1, 0, 32'h000F, "R1/R4/R5");  // pin1 masked still passes, pin5 disabled
    drive(16'h002F);
    expect_at(1, 0, 32'h0000, "R1");        // nothing held
    drive(16'h0000);
    spi_in = 4'hA; expect_at(1, 1, 32'hA, "R2"); idle(1);
    spi_in = 4'h0; expect_at(1, 1, 32'h0, "R2"); idle(1);
    rd(16'h1000, 32'h0003_0200, "R8");

    // secondary mode
    wr(16'h1004, 32'h1);
    rd(16'h1004, 32'h0, "R7");
    wr(cfg_a(0), 32'h0A);   // rising
    wr(cfg_a(1), 32'h0B);   // falling
    wr(cfg_a(2), 32'h08);   // level high
    wr(cfg_a(3), 32'h0C);   // both edges
    wr(cfg_a(4), 32'h09);   // level low, input low -> latches
    wr(cfg_a(6), 32'h1A);   // rising, masked
    wr(cfg_a(7), 32'h02);   // rising, disabled
    expect_at(2, 0, 32'h0010, "R3");
    idle(2);
    rd(cfg_a(6), 32'h1A, "R8");
    drive(16'h0010);
    wr(cfg_a(4), 32'h109);  // clear pin4
    expect_at(2, 0, 32'h0000, "R6");
    idle(3);
    // rising on pin0: exact two-cycle latency
    expect_at(1, 0, 32'h0000, "R3");
    expect_at(2, 0, 32'h0001, "R3");
    drive(16'h0011);
    drive(16'h0010);
    expect_at(2, 0, 32'h0001, "R3");        // stays latched
    idle(1);
    drive(16'h0012);                         // pin1 rises: no hit
    drive(16'h0010);                         // pin1 falls: hit
    expect_at(2, 0, 32'h0003, "R3");
    idle(2);
    drive(16'h0018);                         // pin3 rises, either-edge
    expect_at(2, 0, 32'h000B, "R3");
    idle(2);
    drive(16'h0058);                         // pin6 rises while masked
    expect_at(2, 0, 32'h000B, "R4");
    idle(2);
    drive(16'h00D8);                         // pin7 rises while disabled
    expect_at(2, 0, 32'h000B, "R5");
    idle(2);
    wr(cfg_a(6), 32'h0A);                    // unmask: held latch appears
    expect_at(2, 0, 32'h004B, "R4");
    idle(2);
    wr(cfg_a(7), 32'h0A);                    // enable: nothing was latched
    expect_at(2, 0, 32'h004B, "R5");
    idle(2);
    drive(16'h00DC);                         // pin2 level high
    expect_at(2, 0, 32'h004F, "R3");
    idle(2);
    expect_at(2, 0, 32'h004B, "R6");         // clear wins over level hit
    expect_at(3, 0, 32'h004F, "R6");
    wr(cfg_a(2), 32'h108);
    idle(3);
    spi_in = 4'h5; expect_at(1, 1, 32'h5, "R2"); idle(1);
    spi_in = 4'h0; expect_at(1, 1, 32'h0, "R2"); idle(1);

    // mode switching clears latches
    expect_at(3, 0, 32'h00DC, "R7");
    wr(16'h1004, 32'h0);
    idle(3);
    expect_at(2, 0, 32'h0000, "R7");
    expect_at(5, 0, 32'h0004, "R7");
    wr(16'h1004, 32'h1);
    idle(8);
    if (q.size() != 0) begin
      n_fail += q.size();
      $display("FAIL R9: %0d expected items never compared, expected 0", q.size());
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule